// File: doc/BRIEF.md
# Write-Once Prescaled Timebase Divider

This block turns a fast input clock into a slow, single-cycle tick enable that paces program and erase timing. It holds one 8-bit configuration word. Bit 6 selects an optional divide-by-8 prescaler ahead of the main divider. Bits 5:0 set the main divide value. Bit 7 is a read-only flag that shows the word has been configured. The tick is an enable that is high for one cycle of the input clock. It is not a derived clock, so all downstream logic stays in the input clock domain.

The configuration accepts one write after reset. That write sets the configured flag, and every later write is dropped until the next reset. When the word is loaded, both counters restart, so the first tick comes exactly one full period after the loading edge. A command gate checks the configured flag. It grants a program or erase request only after the divider has been set up, and refuses the request before that.

Top module: `wo_tick_div`

## Requirements
- R1: After reset, the read-back word is 0x00, `loaded` is 0 and `tick` stays 0 until the word is written.
- R2: The first write after reset stores write bits 6:0. Later writes change neither the read-back word nor the tick rate.
- R3: Read-back bit 7 cannot be written. It reads 1 from the cycle after the first write, whatever value was written to bit 7, and it stays 1 until reset.
- R4: With stored bit 6 = 1, the input clock is divided by 8 before the main divider. With bit 6 = 0, the input clock drives the main divider directly.
- R5: `tick` is high for one input cycle once every (D+1)*P input cycles. D is stored bits 5:0, and P is 8 when the prescaler is on and 1 when it is off. The largest ratio is 512 (D=63, P=8), and D=0 with P=1 gives a tick every cycle.
- R6: With the prescaler off and D=4, there is exactly one tick per 5 input cycles, so a 950 kHz input gives a 190 kHz tick rate.
- R7: While `cmd_req` is high, `cmd_refuse` is high and `cmd_grant` is low if `loaded` is 0. If `loaded` is 1, `cmd_grant` is high and `cmd_refuse` is low. Both are low when there is no request.
- R8: Both counters restart on the loading write. If the write is sampled at clock edge E, the first tick is high in the cycle that begins (D+1)*P-1 edges after E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 8 | Write data: bit 6 prescaler enable, bits 5:0 divide value, bit 7 ignored |
| cfg_rdata | output | 8 | Read-back: bit 7 configured flag, bit 6 prescaler enable, bits 5:0 divide value |
| loaded | output | 1 | Configured flag, passed to the command controller |
| tick | output | 1 | One-cycle timebase enable |
| cmd_req | input | 1 | Request to start a program or erase command |
| cmd_grant | output | 1 | Request accepted (divider configured) |
| cmd_refuse | output | 1 | Request refused (divider not configured) |

## Verification
The bench checks the write-once rule by writing a second, very different word. A design that let that write through would show a new read-back value and a shorter tick spacing. It writes 0 to bit 7 and expects 1 back, which catches a flag that can be written or that fails to set. The bench measures the edge count from the loading write to the first tick, with the prescaler on. A design that does not restart its counters, or is off by one in either stage, would give a count other than 47. It also exercises the extremes: the ratio of 512 and the tick every cycle. A wrong terminal count in either counter shows up there as a wrong tick total.

// File: rtl/wo_tick_div_pkg.sv
package wo_tick_div_pkg;
  localparam int DIV_W     = 6;
  localparam int PRE_RATIO = 8;
  localparam int REG_W     = DIV_W + 2;
  localparam int PRE_W     = $clog2(PRE_RATIO);

  typedef struct packed {
    logic             loaded;
    logic             pre_en;
    logic [DIV_W-1:0] div;
  } tdiv_cfg_t;
endpackage

// File: rtl/wo_tick_div_rst.sv
module wo_tick_div_rst #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/wo_tick_div_cfg.sv
module wo_tick_div_cfg
  import wo_tick_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [REG_W-2:0] wdata,
  output tdiv_cfg_t        cfg,
  output logic             restart
);
  logic             loaded_q, loaded_d;
  logic             pre_q, pre_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic             accept;

  assign accept = we & ~loaded_q;

  always_comb begin
    loaded_d = loaded_q;
    pre_d    = pre_q;
    div_d    = div_q;
    if (accept) begin
      loaded_d = 1'b1;
      pre_d    = wdata[DIV_W];
      div_d    = wdata[DIV_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded_q <= 1'b0;
      pre_q    <= 1'b0;
      div_q    <= '0;
    end else if (accept) begin
      loaded_q <= loaded_d;
      pre_q    <= pre_d;
      div_q    <= div_d;
    end
  end

  assign cfg     = '{loaded: loaded_q, pre_en: pre_q, div: div_q};
  assign restart = accept;

  // R2: once configured, the stored fields never change
  a_r2_write_once: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |=> ($stable(pre_q) && $stable(div_q)));
  // R3: the flag sets after any write and then stays set
  a_r3_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> loaded_q);
  a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |=> loaded_q);
endmodule

// File: rtl/wo_tick_div_pre.sv
module wo_tick_div_pre
  import wo_tick_div_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic pre_en,
  output logic strobe
);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_RATIO - 1);

  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  assign at_last = (cnt_q == PRE_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !pre_en) cnt_d = '0;
    else if (at_last)       cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign strobe = pre_en ? at_last : 1'b1;

  // R4: with the prescaler on, two strobes are never adjacent
  a_r4_pre_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_en && strobe) |=> !strobe);
endmodule

// File: rtl/wo_tick_div_cnt.sv
module wo_tick_div_cnt
  import wo_tick_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             strobe,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             at_end;

  assign at_end = (cnt_q == div);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)     cnt_d = '0;
    else if (strobe) cnt_d = at_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = run & strobe & at_end;

  // R5: the main count never passes the divide value
  a_r5_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= div);
  // R5: the tick is a single-cycle pulse unless the ratio is 1
  a_r5_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> !tick);
endmodule

// File: rtl/wo_tick_div.sv
module wo_tick_div
  import wo_tick_div_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [REG_W-1:0] cfg_wdata,
  output logic [REG_W-1:0] cfg_rdata,
  output logic             loaded,
  output logic             tick,
  input  logic             cmd_req,
  output logic             cmd_grant,
  output logic             cmd_refuse
);
  logic      rst_int_n;
  tdiv_cfg_t cfg;
  logic      restart;
  logic      strobe;
  logic      unused_wbit;

  assign unused_wbit = cfg_wdata[REG_W-1];

  wo_tick_div_rst #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  wo_tick_div_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .we      (cfg_we),
    .wdata   (cfg_wdata[REG_W-2:0]),
    .cfg     (cfg),
    .restart (restart)
  );

  wo_tick_div_pre u_pre (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (restart),
    .pre_en  (cfg.pre_en),
    .strobe  (strobe)
  );

  wo_tick_div_cnt u_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .restart (restart),
    .strobe  (strobe),
    .run     (cfg.loaded),
    .div     (cfg.div),
    .tick    (tick)
  );

  assign cfg_rdata  = cfg;
  assign loaded     = cfg.loaded;
  assign cmd_grant  = cmd_req & cfg.loaded;
  assign cmd_refuse = cmd_req & ~cfg.loaded;

  // R1: no tick before configuration
  a_r1_quiet_unloaded: assert property (@(posedge clk) disable iff (!rst_int_n)
    !loaded |-> !tick);
  // R7: a request gets exactly one answer
  a_r7_one_answer: assert property (@(posedge clk) disable iff (!rst_int_n)
    cmd_req |-> (cmd_grant != cmd_refuse));
  a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cmd_req |-> !(cmd_grant || cmd_refuse));
endmodule

// File: tb/wo_tick_div_tb.sv
module wo_tick_div_tb;
  logic       clk;
  logic       rst_n;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       loaded;
  logic       tick;
  logic       cmd_req;
  logic       cmd_grant;
  logic       cmd_refuse;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  wo_tick_div u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_wdata  (cfg_wdata),
    .cfg_rdata  (cfg_rdata),
    .loaded     (loaded),
    .tick       (tick),
    .cmd_req    (cmd_req),
    .cmd_grant  (cmd_grant),
    .cmd_refuse (cmd_refuse)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference: configured flag, stored value, edges since load
  bit       m_loaded = 0;
  bit [6:0] m_val    = '0;
  int       m_t      = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_loaded = 0;
      m_val    = '0;
      m_t      = 0;
    end else if (cfg_we && !m_loaded) begin
      m_loaded = 1;
      m_val    = cfg_wdata[6:0];
      m_t      = 0;
    end else if (m_loaded) begin
      m_t = m_t + 1;
    end
  end

  function automatic int m_period();
    return (int'(m_val[5:0]) + 1) * (m_val[6] ? 8 : 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  bit cmp_en = 0;
  always @(negedge clk) begin
    if (cmp_en && rst_n) begin
      chk("R2/R3 readback", cfg_rdata, {m_loaded, m_val});
      chk("R5/R8 tick", tick, (m_loaded && ((m_t + 1) % m_period() == 0)) ? 1 : 0);
      chk("R7 grant", cmd_grant, (cmd_req && m_loaded) ? 1 : 0);
      chk("R7 refuse", cmd_refuse, (cmd_req && !m_loaded) ? 1 : 0);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we    = 1'b0;
    cfg_wdata = 8'h00;
  endtask

  task automatic count_ticks(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      if (tick) cnt++;
      @(negedge clk);
    end
  endtask

  task automatic first_tick(output int n);
    n = 0;
    while (!tick && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = 8'h00; cmd_req = 1'b0;
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_en = 1;

    // R1 reset state
    chk("R1 rdata", cfg_rdata, 8'h00);
    chk("R1 loaded", loaded, 0);
    count_ticks(20, n);
    chk("R1 no tick unloaded", n, 0);

    // R7 refused before configuration
    cmd_req = 1'b1;
    @(negedge clk);
    chk("R7 refuse unloaded", cmd_refuse, 1);
    chk("R7 no grant unloaded", cmd_grant, 0);

    // R3 bit 7 written as 0 reads back 1; R6 example ratio 5
    wr(8'h04);
    chk("R3 flag set", cfg_rdata, 8'h84);
    chk("R7 grant loaded", cmd_grant, 1);
    cmd_req = 1'b0;
    count_ticks(500, n);
    chk("R6 ticks in 500 cycles", n, 100);

    // R2 second write ignored
    wr(8'h7F);
    chk("R2 readback kept", cfg_rdata, 8'h84);
    count_ticks(100, n);
    chk("R2 rate kept", n, 20);

    // R3 flag clears only on reset
    do_reset();
    chk("R3 flag cleared by reset", loaded, 0);

    // R5 maximum ratio 512
    wr(8'h7F);
    chk("R4 prescaler stored", cfg_rdata, 8'hFF);
    count_ticks(1100, n);
    chk("R5 ticks at ratio 512", n, 2);

    // R8 first tick one period after load (prescaler on, D=5 -> 48)
    do_reset();
    wr(8'h45);
    first_tick(n);
    chk("R8 edges to first tick", n, 47);
    count_ticks(480, n);
    chk("R4 ticks at ratio 48", n, 10);

    // R5 ratio 1: tick every cycle
    do_reset();
    wr(8'h00);
    count_ticks(30, n);
    chk("R5 ratio 1 ticks", n, 30);

    // R4 prescaler on with D=0 gives ratio 8
    do_reset();
    wr(8'h40);
    first_tick(n);
    chk("R4 first tick ratio 8", n, 7);

    cmp_en = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule